// File: doc/BRIEF.md
# Frame-Synchronised Serial Command Port

This block is the host side of a serial command link to a peripheral that owns the bit clock. The peripheral's clock runs continuously and is the block's only clock. A host issues one register read or write at a time on a parallel request interface. The block turns each request into a 16-bit command word. The word is preceded by a single-cycle, active-high transmit frame-sync pulse and is shifted out most significant bit first.

For a read, the peripheral answers on its own receive frame-sync and data lines. The answer can start while the command word is still being sent, so the receiver runs alongside the transmitter. The receiver waits for the reply's frame sync and shifts in either 16 or 32 bits. It keeps only the final byte, which it presents with a one-cycle valid strobe. If no reply frame sync turns up within a fixed window, a timeout pulse ends the request.

Transmit outputs change on the rising edge of the bit clock, and the peripheral samples them on the falling edge. The receive inputs are sampled on the falling edge.

Top module: `fsb_cmd_port`

## Requirements
- R1: While reset is high and after it is released, busy, tx_fs, tx_dat, rsp_valid and timeout are all 0.
- R2: A request is taken on a rising edge where req_valid is 1 and busy is 0. busy is 1 from the next cycle until the request completes. A request presented while busy is 1 is ignored.
- R3: Cycle 0 is the cycle after acceptance, and tx_fs is 1 for that cycle only. In cycles 1 to 16, tx_dat carries the 16 word bits, most significant first. tx_dat is 0 in every other cycle.
- R4: A read is encoded as bit 15 = 0, bits 14:8 = address and bits 7:0 = 0. A write is encoded as bit 15 = 1, bits 14:8 = address and bits 7:0 = write data.
- R5: A write raises neither rsp_valid nor timeout. busy drops in cycle 17, the cycle after the last bit.
- R6: During a read, rx_fs is sampled on falling edges. After a falling edge that sees it high, the next N falling edges shift in rx_dat, most significant first. rsp_data is the last 8 bits received. rsp_valid is 1 for exactly one cycle, namely the cycle after the one holding the last bit, and busy is 0 in that same cycle.
- R7: The reply frame sync may arrive in any cycle from 0 up to the end of the timeout window, including the cycles 10 to 12 that overlap the command word. Capture is the same in every case.
- R8: A reply frame sync may be seen in any of cycles 0 to TMO-1 (TMO = 32 by default). If none is seen there, timeout is 1 for cycle TMO only, busy is 0 in that cycle, and a later frame produces no response.
- R9: rx_fs and rx_dat are ignored when no read is outstanding, that is while idle or during a write.
- R10: N is 16 when rx_long is 0 and 32 when rx_long is 1. rx_long is read at the reply frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Continuous bit clock from the peripheral |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data byte |
| rx_long | input | 1 | Receive word length: 0 = 16 bits, 1 = 32 bits |
| rx_fs | input | 1 | Receive frame sync from the peripheral |
| rx_dat | input | 1 | Receive serial data from the peripheral |
| busy | output | 1 | A request is in progress |
| tx_fs | output | 1 | Transmit frame-sync pulse |
| tx_dat | output | 1 | Transmit serial data |
| rsp_valid | output | 1 | One-cycle strobe marking a read byte |
| rsp_data | output | DATA_W | Captured read byte |
| timeout | output | 1 | One-cycle pulse marking a reply that never arrived |

## Verification
The bench builds the block with its defaults: a 7-bit address, an 8-bit data byte and a 32-cycle timeout window. With these values every address is swept through a write, and every data byte comes back through a read, with rx_long alternating and reply offsets of 10 to 12. A delay sweep from 0 to 40 cycles places the reply frame sync on both sides of the timeout boundary at 31 and 32. Reply frames injected while the block is idle or writing, and requests raised mid-transaction, show that the inputs meant to be ignored leave the outputs unchanged.

// File: rtl/fsb_cmd_port.sv
module fsb_cmd_port #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int TMO    = 32
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rx_long,
  input  logic              rx_fs,
  input  logic              rx_dat,
  output logic              busy,
  output logic              tx_fs,
  output logic              tx_dat,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              timeout
);
  localparam int WORD_W = 1 + ADDR_W + DATA_W;
  localparam int TXC_W  = $clog2(WORD_W + 2);
  localparam int RXC_W  = $clog2(2 * WORD_W + 1);
  localparam int TC_W   = $clog2(TMO + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t               st;
  logic [WORD_W-1:0] tx_sr;
  logic [TXC_W-1:0]  tx_cnt;
  logic [TC_W-1:0]   tcnt;
  logic [DATA_W-1:0] rx_sr;
  logic [RXC_W-1:0]  rx_cnt;
  logic              rx_started, rx_done;

  assign busy = (st != S_IDLE) || (tx_cnt != '0);
  wire accept = req_valid && !busy;
  wire armed  = (st == S_RD);

  // launch side: rising edge
  always_ff @(posedge sclk) begin
    if (rst) begin
      st        <= S_IDLE;
      tx_sr     <= '0;
      tx_cnt    <= '0;
      tcnt      <= '0;
      tx_fs     <= 1'b0;
      tx_dat    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      timeout   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      timeout   <= 1'b0;
      if (accept) begin
        st     <= req_write ? S_WR : S_RD;
        tx_sr  <= {req_write, req_addr, req_write ? req_wdata : {DATA_W{1'b0}}};
        tx_cnt <= TXC_W'(WORD_W + 1);
        tx_fs  <= 1'b1;
        tx_dat <= 1'b0;
        tcnt   <= '0;
      end else begin
        if (tx_cnt != '0) begin
          tx_cnt <= tx_cnt - 1'b1;
          tx_fs  <= 1'b0;
          tx_dat <= (tx_cnt > TXC_W'(1)) ? tx_sr[WORD_W-1] : 1'b0;
          tx_sr  <= tx_sr << 1;
        end
        case (st)
          S_RD: begin
            if (!rx_started) tcnt <= tcnt + 1'b1;
            if (rx_done) begin
              st        <= S_IDLE;
              rsp_valid <= 1'b1;
              rsp_data  <= rx_sr;
            end else if (!rx_started && tcnt == TC_W'(TMO - 1)) begin
              st      <= S_IDLE;
              timeout <= 1'b1;
            end
          end
          S_WR: if (tx_cnt == TXC_W'(1)) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  // capture side: falling edge
  always_ff @(negedge sclk) begin
    if (rst || !armed) begin
      rx_cnt     <= '0;
      rx_started <= 1'b0;
      rx_done    <= 1'b0;
      if (rst) rx_sr <= '0;
    end else if (rx_cnt != '0) begin
      rx_sr  <= {rx_sr[DATA_W-2:0], rx_dat};
      rx_cnt <= rx_cnt - 1'b1;
      if (rx_cnt == RXC_W'(1)) rx_done <= 1'b1;
    end else if (!rx_started && rx_fs) begin
      rx_started <= 1'b1;
      rx_cnt     <= rx_long ? RXC_W'(2 * WORD_W) : RXC_W'(WORD_W);
    end
  end

  assert_fs_single_R3: assert property (@(posedge sclk) disable iff (rst)
    tx_fs |=> !tx_fs);
  assert_accept_busy_R2: assert property (@(posedge sclk) disable iff (rst)
    (req_valid && !busy) |=> (busy && tx_fs));
  assert_fs_needs_busy_R3: assert property (@(posedge sclk) disable iff (rst)
    tx_fs |-> busy);
  assert_rsp_idle_R6: assert property (@(posedge sclk) disable iff (rst)
    rsp_valid |-> !busy);
  assert_tmo_idle_R8: assert property (@(posedge sclk) disable iff (rst)
    timeout |-> (!busy && !rsp_valid));
  assert_rsp_pulse_R6: assert property (@(posedge sclk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sim_fsb_cmd_port.sv
module sim_fsb_cmd_port;
  localparam int CLK_P = 10;
  logic sclk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, rx_long = 0, rx_fs = 0, rx_dat = 0;
  logic [6:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic busy, tx_fs, tx_dat, rsp_valid, timeout;
  logic [7:0] rsp_data;
  int errors = 0, checks = 0;

  fsb_cmd_port u0 (.sclk(sclk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rx_long(rx_long), .rx_fs(rx_fs),
    .rx_dat(rx_dat), .busy(busy), .tx_fs(tx_fs), .tx_dat(tx_dat), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .timeout(timeout));

  always #(CLK_P/2) sclk = ~sclk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xact(input bit wr, input logic [6:0] a, input logic [7:0] d,
                      input int dly, input bit lng, input bit poke);
    logic [15:0] exp_w, got;
    logic [31:0] rep;
    int len, done_k;
    bit tmo, fs_ok, dat_ok, busy_ok, rsp_ok, to_ok;
    exp_w = {wr, a, wr ? d : 8'h00};
    len = lng ? 32 : 16;
    tmo = !wr && dly >= 32;
    done_k = wr ? 17 : (tmo ? 32 : dly + len + 1);
    rep = lng ? {~d, d ^ 8'hA5, 8'h3C ^ {1'b0, a}, d} : {16'h0, ~d, d};
    got = 0; fs_ok = 1; dat_ok = 1; busy_ok = 1; rsp_ok = 1; to_ok = 1;
    rx_long = lng;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1;
    @(posedge sclk); #1 req_valid = 0;
    for (int k = 0; k <= done_k + 1; k++) begin
      if (k > 0) begin @(posedge sclk); #1; end
      rx_fs  = (k == dly);
      rx_dat = (k > dly && k <= dly + len) ? rep[len - 1 - (k - dly - 1)] : 1'b0;
      if (poke && k == 5) begin
        req_valid = 1; req_addr = ~a; req_write = !wr; req_wdata = ~d;
      end
      if (k == 6) req_valid = 0;
      @(negedge sclk); #1;
      fs_ok &= (tx_fs == (k == 0));
      if (k >= 1 && k <= 16) got[16 - k] = tx_dat;
      else if (k > 0) dat_ok &= (tx_dat == 0);
      busy_ok &= (busy == (k < done_k));
      rsp_ok  &= (rsp_valid == (!wr && !tmo && k == done_k));
      if (!wr && !tmo && k == done_k) rsp_ok &= (rsp_data == d);
      to_ok &= (timeout == (tmo && k == done_k));
    end
    rx_fs = 0; rx_dat = 0;
    chk(fs_ok,  "R3 tx_fs single pulse", tx_fs, 0);
    chk(dat_ok && got == exp_w, "R3/R4 tx word", got, exp_w);
    chk(busy_ok, poke ? "R2 busy span with ignored request" : (wr ? "R5 write busy span" : "R2 busy span"), busy, 0);
    chk(rsp_ok, wr ? "R9 no response on write" : (lng ? "R10 R6 long capture" : "R6 R7 capture"), rsp_data, d);
    chk(to_ok, tmo ? "R8 timeout pulse" : "R8 no spurious timeout", timeout, tmo);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) begin
      @(negedge sclk); #1;
      chk({busy, tx_fs, tx_dat, rsp_valid, timeout} == 0, "R1 in reset",
          {busy, tx_fs, tx_dat, rsp_valid, timeout}, 0);
    end
    @(posedge sclk); #1 rst = 0;
    @(negedge sclk); #1;
    chk({busy, tx_fs, tx_dat, rsp_valid, timeout} == 0, "R1 after reset",
        {busy, tx_fs, tx_dat, rsp_valid, timeout}, 0);
    // R4 R5 R9: all write addresses, with a stray reply frame at offset 3
    for (int a = 0; a < 128; a++) xact(1, 7'(a), 8'(a * 3 + 7), 3, a[0], 0);
    // R6 R7 R10: every data byte, reply offsets 10..12, both lengths
    for (int i = 0; i < 256; i++) xact(0, 7'(i), 8'(i), 10 + i % 3, i[3], 0);
    // R7 R8: reply offset sweep across the timeout boundary
    for (int dl = 0; dl <= 40; dl++) xact(0, 7'(dl), ~8'(dl), dl, dl[0], 0);
    // R2: requests raised while busy
    xact(0, 7'h05, 8'h99, 11, 0, 1);
    xact(1, 7'h6A, 8'h3C, 4, 0, 1);
    // R9: reply frame while idle
    ok = 1;
    for (int k = 0; k < 40; k++) begin
      @(posedge sclk); #1;
      rx_fs = (k == 2); rx_dat = k[1];
      @(negedge sclk); #1;
      ok &= !rsp_valid && !busy && !timeout && !tx_fs;
    end
    rx_fs = 0; rx_dat = 0;
    chk(ok, "R9 idle frame ignored", rsp_valid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule